// File: doc/BRIEF.md
# Reversible-Cell Ripple Adder/Subtractor

This block adds or subtracts two unsigned 16-bit operands through a ripple chain of identical one-bit cells. Each cell is written at gate level as a four-input, four-output reversible gate. One input is a control line and three are data lines (operand bit, second operand bit, incoming carry or borrow). The four outputs are the result bit, the outgoing carry or borrow, and two lines that a reversible gate must keep. Those two lines are the pass-through of the first operand bit and an auxiliary line. The one mode bit is fanned out to the control line of every cell, so the whole chain is either an adder or a subtractor.

The block is one of several arithmetic units that sit behind a one-hot unit select. While its enable is low, the operands are gated off the chain so that it stays idle, and the registered outputs read zero. The extra lines of every cell are gathered into one garbage bus, so that the state of each cell can be inspected. The outputs are registered once, so a result appears one clock after its operands.

Top module: `rvas_addsub`

## Requirements
- R1: With enable high and mode 0 on a clock edge, the next cycle shows {carry out, result} equal to the 17-bit unsigned sum a + b + carry-in.
- R2: With enable high and mode 1, the next cycle shows a result equal to (a - b - borrow-in) modulo 2^16.
- R3: With enable high and mode 1, carry out in the next cycle is 1 exactly when the unsigned a is smaller than b + borrow-in.
- R4: With enable high, garbage bit 2i in the next cycle equals a[i] in both modes, for every i from 0 to 15.
- R5: With enable high, garbage bit 2i+1 in the next cycle equals b[i] in mode 0. In mode 1 it equals the inverse of the borrow entering cell i. The borrow entering cell 0 is borrow-in, and the borrow entering cell i is 1 when a[i-1:0] < b[i-1:0] + borrow-in.
- R6: With enable low on a clock edge, result, carry out and the whole garbage bus are zero in the next cycle, whatever the operands, mode and carry-in.
- R7: A clock edge with synchronous reset high clears result, carry out and garbage to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Unit enable from the one-hot select |
| mode_i | input | 1 | 0 = add, 1 = subtract; drives every cell's control line |
| a_i | input | 16 | First operand (minuend when subtracting) |
| b_i | input | 16 | Second operand (subtrahend when subtracting) |
| cin_i | input | 1 | Carry-in (add) or borrow-in (subtract) |
| res_o | output | 16 | Registered sum or difference |
| cout_o | output | 1 | Registered carry-out or borrow-out |
| garbage_o | output | 32 | Registered extra cell lines; bit 2i is cell i pass-through, bit 2i+1 its auxiliary line |

## Verification
A cell whose control line were cut from the mode bit would compute a carry where a borrow is due. That error appears one cycle later in the result bits above that cell, and in its auxiliary garbage bit, which shows b[i] in place of the inverted borrow. A break in the ripple chain shows up only when the carry or borrow reaches that cell. For this reason the vectors include all-ones and zero operands with carry-in set, so that a carry or borrow runs the full width. Because each cell's incoming carry or borrow is visible on the garbage bus, a fault can be placed at a single bit position from the port values alone.

// File: rtl/rvas_pkg.sv
package rvas_pkg;

    localparam int unsigned RVAS_WIDTH = 16;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } rvas_op_e;

    // Four lines into a reversible cell
    typedef struct packed {
        rvas_op_e ctl;   // control line
        logic     x;     // first operand bit
        logic     y;     // second operand bit
        logic     z;     // incoming carry / borrow
    } rvas_cell_in_t;

    // Four lines out of a reversible cell
    typedef struct packed {
        logic thru;      // pass-through of x
        logic aux;       // y when adding, ~z when subtracting
        logic cb;        // outgoing carry / borrow
        logic bit_res;   // sum or difference bit
    } rvas_cell_out_t;

    function automatic logic rvas_xor3(input logic p, input logic q, input logic r);
        return p ^ q ^ r;
    endfunction

endpackage

// File: rtl/rvas_cell.sv
module rvas_cell
    import rvas_pkg::*;
(
    input  rvas_cell_in_t  cin_s,
    output rvas_cell_out_t cout_s
);
    logic ctl_b;
    logic sel_x;
    logic yz_diff;
    logic yz_both;

    assign ctl_b   = (cin_s.ctl == OP_SUB);
    assign sel_x   = ctl_b ^ cin_s.x;
    assign yz_diff = cin_s.y ^ cin_s.z;
    assign yz_both = cin_s.y & cin_s.z;

    always_comb begin
        cout_s.thru    = cin_s.x;
        cout_s.aux     = ctl_b ? ~cin_s.z : cin_s.y;
        cout_s.cb      = (sel_x & yz_diff) ^ yz_both;
        cout_s.bit_res = rvas_xor3(cin_s.x, cin_s.y, cin_s.z);
    end

endmodule

// File: rtl/rvas_chain.sv
module rvas_chain
    import rvas_pkg::*;
#(
    parameter int unsigned WIDTH = RVAS_WIDTH
) (
    input  logic               mode,
    input  logic [WIDTH-1:0]   opa,
    input  logic [WIDTH-1:0]   opb,
    input  logic               cbin,
    output logic [WIDTH-1:0]   res,
    output logic               cbout,
    output logic [2*WIDTH-1:0] garb
);
    logic [WIDTH:0] link;

    assign link[0] = cbin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        rvas_cell_in_t  ci;
        rvas_cell_out_t co;

        always_comb begin
            ci.ctl = rvas_op_e'(mode);
            ci.x   = opa[i];
            ci.y   = opb[i];
            ci.z   = link[i];
        end

        rvas_cell u_cell (
            .cin_s  (ci),
            .cout_s (co)
        );

        assign res[i]         = co.bit_res;
        assign link[i+1]      = co.cb;
        assign garb[2*i]      = co.thru;
        assign garb[2*i+1]    = co.aux;
    end

    assign cbout = link[WIDTH];

endmodule

// File: rtl/rvas_addsub.sv
module rvas_addsub
    import rvas_pkg::*;
#(
    parameter int unsigned WIDTH = RVAS_WIDTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic               mode_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic               cin_i,
    output logic [WIDTH-1:0]   res_o,
    output logic               cout_o,
    output logic [2*WIDTH-1:0] garbage_o
);
    localparam int unsigned GW = 2 * WIDTH;
    localparam int unsigned EW = WIDTH + 1;

    // operands gated so an idle unit keeps its chain quiet
    logic             g_mode;
    logic [WIDTH-1:0] g_a;
    logic [WIDTH-1:0] g_b;
    logic             g_cin;

    assign g_mode = mode_i & en_i;
    assign g_a    = a_i & {WIDTH{en_i}};
    assign g_b    = b_i & {WIDTH{en_i}};
    assign g_cin  = cin_i & en_i;

    logic [WIDTH-1:0] c_res;
    logic             c_cout;
    logic [GW-1:0]    c_garb;

    rvas_chain #(.WIDTH(WIDTH)) u_chain (
        .mode  (g_mode),
        .opa   (g_a),
        .opb   (g_b),
        .cbin  (g_cin),
        .res   (c_res),
        .cbout (c_cout),
        .garb  (c_garb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o     <= '0;
            cout_o    <= 1'b0;
            garbage_o <= '0;
        end else if (en_i) begin
            res_o     <= c_res;
            cout_o    <= c_cout;
            garbage_o <= c_garb;
        end else begin
            res_o     <= '0;
            cout_o    <= 1'b0;
            garbage_o <= '0;
        end
    end

    // R1: sum with carry
    a_r1_sum: assert property (@(posedge clk) disable iff (rst)
        en_i && !mode_i |=> {cout_o, res_o} ==
            ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + EW'($past(cin_i))));

    // R2: difference modulo 2^WIDTH
    a_r2_diff: assert property (@(posedge clk) disable iff (rst)
        en_i && mode_i |=> res_o == ($past(a_i) - $past(b_i) - WIDTH'($past(cin_i))));

    // R3: borrow out
    a_r3_borrow: assert property (@(posedge clk) disable iff (rst)
        en_i && mode_i |=> cout_o ==
            ({1'b0, $past(a_i)} < ({1'b0, $past(b_i)} + EW'($past(cin_i)))));

    // R4: pass-through lines
    for (genvar k = 0; k < WIDTH; k++) begin : g_chk
        a_r4_pass: assert property (@(posedge clk) disable iff (rst)
            en_i |=> garbage_o[2*k] == $past(a_i[k]));
    end

    // R6: idle unit reads zero
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (res_o == '0) && !cout_o && (garbage_o == '0));

    // R7: reset clears outputs
    a_r7_reset_zero: assert property (@(posedge clk)
        rst |=> (res_o == '0) && !cout_o && (garbage_o == '0));

endmodule

// File: tb/tb_rvas_addsub.sv
module tb_rvas_addsub;

    localparam int W = 16;
    localparam int NV = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en_i = 1'b0;
    logic            mode_i = 1'b0;
    logic [W-1:0]    a_i = '0;
    logic [W-1:0]    b_i = '0;
    logic            cin_i = 1'b0;
    logic [W-1:0]    res_o;
    logic            cout_o;
    logic [2*W-1:0]  garbage_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    rvas_addsub dut (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .mode_i    (mode_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .cin_i     (cin_i),
        .res_o     (res_o),
        .cout_o    (cout_o),
        .garbage_o (garbage_o)
    );

    // {mode, cin, a, b}
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h0000, 16'h0000},
        {1'b0, 1'b1, 16'hFFFF, 16'hFFFF},
        {1'b0, 1'b0, 16'hFFFF, 16'h0001},
        {1'b0, 1'b0, 16'h1234, 16'h1234},
        {1'b0, 1'b0, 16'h8000, 16'h8000},
        {1'b1, 1'b0, 16'h0000, 16'h0000},
        {1'b1, 1'b1, 16'h0000, 16'h0000},
        {1'b1, 1'b0, 16'hFFFF, 16'hFFFF},
        {1'b1, 1'b1, 16'h1234, 16'h1234},
        {1'b1, 1'b0, 16'h0005, 16'h0007},
        {1'b1, 1'b1, 16'hFFFF, 16'h0000},
        {1'b1, 1'b0, 16'h8000, 16'h7FFF}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] exp_garb(input logic m, input logic c,
                                                  input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] g;
        g = '0;
        for (int i = 0; i < W; i++) begin
            logic [W:0] mask;
            logic [W:0] am;
            logic [W:0] bm;
            logic       into;
            mask = (17'd1 << i) - 17'd1;
            am = {1'b0, a} & mask;
            bm = {1'b0, b} & mask;
            if (m) into = (am < bm + 17'(c));
            else   into = ((am + bm + 17'(c)) >> i) != 0;
            g[2*i]   = a[i];
            g[2*i+1] = m ? ~into : b[i];
        end
        return g;
    endfunction

    task automatic run_op(input logic m, input logic c, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0]     sum;
        logic [W-1:0]   diff;
        logic           brw;
        logic [2*W-1:0] g;
        @(negedge clk);
        en_i = 1'b1; mode_i = m; cin_i = c; a_i = a; b_i = b;
        @(negedge clk);
        g = exp_garb(m, c, a, b);
        if (!m) begin
            sum = {1'b0, a} + {1'b0, b} + 17'(c);
            check("R1 result", 64'(res_o), 64'(sum[W-1:0]));
            check("R1 carry", 64'(cout_o), 64'(sum[W]));
        end else begin
            diff = a - b - 16'(c);
            brw  = ({1'b0, a} < {1'b0, b} + 17'(c));
            check("R2 result", 64'(res_o), 64'(diff));
            check("R3 borrow", 64'(cout_o), 64'(brw));
        end
        for (int i = 0; i < W; i++) begin
            if (garbage_o[2*i] !== g[2*i]) begin
                checks++; failures++;
                $display("FAIL R4 bit %0d actual=%b expected=%b", i, garbage_o[2*i], g[2*i]);
            end
        end
        checks++;
        check("R5 aux lines", 64'(garbage_o), 64'(g));
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        en_i = 1'b1; mode_i = 1'b1; a_i = 16'hABCD; b_i = 16'h1111; cin_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7 result", 64'(res_o), 64'd0);
        check("R7 carry", 64'(cout_o), 64'd0);
        check("R7 garbage", 64'(garbage_o), 64'd0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][33], VEC[v][32], VEC[v][31:16], VEC[v][15:0]);
        end

        for (int r = 0; r < 40; r++) begin
            run_op(1'(r % 2), 1'($urandom), 16'($urandom), 16'($urandom));
        end

        // R6: enable low after a nonzero result
        run_op(1'b0, 1'b1, 16'hFFFF, 16'h00F0);
        @(negedge clk);
        en_i = 1'b0; mode_i = 1'b1; a_i = 16'h5A5A; b_i = 16'hFFFF; cin_i = 1'b1;
        @(negedge clk);
        check("R6 result", 64'(res_o), 64'd0);
        check("R6 carry", 64'(cout_o), 64'd0);
        check("R6 garbage", 64'(garbage_o), 64'd0);

        // R7: reset mid-run clears a live result
        run_op(1'b1, 1'b1, 16'h0000, 16'h0000);
        @(negedge clk);
        rst = 1'b1; en_i = 1'b1;
        @(negedge clk);
        check("R7 result mid", 64'(res_o), 64'd0);
        check("R7 carry mid", 64'(cout_o), 64'd0);
        check("R7 garbage mid", 64'(garbage_o), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule